// File: doc/BRIEF.md
# Two-Bit-Instruction Boundary-Scan Test Port

This block is the serial test port of a chip. It follows the sixteen-state test controller of IEEE 1149.1. Four inputs feed it: the test clock, the mode select, the serial data in and an active-low reset. It returns one serial data output with an output enable. A two-bit instruction register picks the data register that sits between data in and data out. It also decides whether the boundary cells take over the chip's pins.

The instruction register decodes codes as follows:

- `11` selects the one-stage bypass register.
- `01` and `10` both select the sample/preload function. The boundary chain is captured from the pins and loaded from the serial input, but the pins stay with the core.
- `00` selects the external-test function. The boundary update register then drives the pins.

The boundary chain length is a parameter. Chain bit 0 is nearest the serial output.

Every flop uses the rising test-clock edge, except the output stage, which uses the falling edge. Reset is synchronous to the test clock and active low. It must be held across at least one full clock period.

Top module: `scan_tap`

## Requirements
- R1: With instruction `00` active, `pin_drive` is 1. With any other instruction active, it is 0.
- R2: Instruction codes `01` and `10` behave alike. Capture-DR loads the boundary chain from `pin_in`, Shift-DR shifts it, and `pin_drive` stays 0.
- R3: With instruction `11` active, Capture-DR loads the bypass stage with 0. Shift-DR then gives a one-bit path: each bit on `tdo` is the `tdi` bit sampled on the previous rising edge.
- R4: Five rising edges with `tms` high reach Test-Logic-Reset from any state. Entering that state makes `11` the active instruction.
- R5: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tms` and `tdi` are sampled only on the rising edge.
- R6: `tdo_oe` is 1 exactly while the controller is in Shift-IR or Shift-DR. Otherwise it is 0 and `tdo` is 0.
- R7: Capture-IR loads the fixed value `01` into the instruction shift stage, least significant bit out first. The active instruction changes only on Update-IR or on entering Test-Logic-Reset.
- R8: In a boundary scan, chain bit 0 leaves first. So the k-th bit out after Capture-DR is `pin_in[k]`, and `tdi` enters at bit N-1.
- R9: `pin_out` takes the shifted boundary contents on Update-DR under any instruction other than `11`. It holds its value at every other time.
- R10: When `trst_n` is low at a rising edge, the controller goes to Test-Logic-Reset, the active instruction becomes `11` and `pin_out` clears. At the next falling edge `tdo_oe` goes to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Active-low synchronous test reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| pin_in | input | BSR_LEN | Values present on the chip pins, captured into the chain |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`, active high |
| pin_out | output | BSR_LEN | Boundary update register contents |
| pin_drive | output | 1 | High when the boundary cells own the pins |

## Verification
The bench carries its own model of the controller, instruction register and chain, and compares it against the ports on every clock. It reads back the captured instruction value. A design that captured a different pattern, or shifted most significant bit first, would return `10` instead of `01`. It loads both sample codes and checks the pins stay with the core. A decoder that covered only one of `01` and `10` would raise `pin_drive` or route the bypass stage. It checks that bypass adds exactly one bit of delay, and that the boundary chain returns the pin values starting at bit 0. An off-by-one capture or a reversed chain would show up as shifted or mirrored data. It drives five `tms`-high clocks out of the external-test state, where a controller that skipped the instruction reload would leave the pins driven.

// File: rtl/scan_tap_pkg.sv
// Shared types for the scan test port: controller state encoding and
// instruction decode helpers. Assumes a two-bit instruction register.
package scan_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET    = 4'hF,
        ST_IDLE     = 4'hC,
        ST_SEL_DR   = 4'h7,
        ST_CAP_DR   = 4'h6,
        ST_SHIFT_DR = 4'h2,
        ST_EXIT1_DR = 4'h1,
        ST_PAUSE_DR = 4'h3,
        ST_EXIT2_DR = 4'h0,
        ST_UPD_DR   = 4'h5,
        ST_SEL_IR   = 4'h4,
        ST_CAP_IR   = 4'hE,
        ST_SHIFT_IR = 4'hA,
        ST_EXIT1_IR = 4'h9,
        ST_PAUSE_IR = 4'hB,
        ST_EXIT2_IR = 4'h8,
        ST_UPD_IR   = 4'hD
    } tap_state_t;

    localparam int IR_W = 2;
    localparam logic [IR_W-1:0] OP_BYPASS  = 2'b11;
    localparam logic [IR_W-1:0] OP_EXTEST  = 2'b00;
    localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

    // True when the instruction routes the one-stage bypass path.
    function automatic logic op_is_bypass(input logic [IR_W-1:0] op);
        return op == OP_BYPASS;
    endfunction

    // True when the instruction lets the boundary cells drive the pins.
    function automatic logic op_is_extest(input logic [IR_W-1:0] op);
        return op == OP_EXTEST;
    endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
// Sixteen-state test controller. Advances on the rising test clock from
// the mode-select input; a low reset at a rising edge forces the reset
// state. Exposes both the current and the next state.
module scan_tap_fsm
    import scan_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state,
    output tap_state_t state_nxt
);

    // Next-state decode from current state and mode select.
    always_comb begin
        unique case (state)
            ST_RESET:    state_nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: state_nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: state_nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: state_nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_nxt = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: state_nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: state_nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: state_nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
            default:     state_nxt = ST_RESET;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= state_nxt;
    end

endmodule

// File: rtl/scan_tap_ir.sv
// Two-bit instruction register: a shift stage that captures a fixed
// pattern and shifts LSB first, and an active stage written on Update-IR.
// The active stage reloads the bypass code on any entry to reset.
module scan_tap_ir
    import scan_tap_pkg::*;
(
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_t      state,
    input  tap_state_t      state_nxt,
    input  logic            tdi,
    output logic            ir_so,
    output logic [IR_W-1:0] ir_active
);

    logic [IR_W-1:0] ir_shift;

    // Shift stage: capture fixed pattern, shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                      ir_shift <= IR_CAPTURE;
        else if (state == ST_CAP_IR)      ir_shift <= IR_CAPTURE;
        else if (state == ST_SHIFT_IR)    ir_shift <= {tdi, ir_shift[IR_W-1:1]};
    end

    // Active stage: reload bypass on reset entry, else take update.
    always_ff @(posedge tck) begin
        if (!trst_n)                      ir_active <= OP_BYPASS;
        else if (state_nxt == ST_RESET)   ir_active <= OP_BYPASS;
        else if (state == ST_UPD_IR)      ir_active <= ir_shift;
    end

    assign ir_so = ir_shift[0];

endmodule

// File: rtl/scan_tap_bsr.sv
// Boundary register chain of LEN cells with a parallel update stage.
// Bit 0 is nearest the serial output; serial input enters at bit LEN-1.
module scan_tap_bsr #(
    parameter int LEN = 8
) (
    input  logic           tck,
    input  logic           trst_n,
    input  logic           cap_en,
    input  logic           shift_en,
    input  logic           upd_en,
    input  logic           tdi,
    input  logic [LEN-1:0] pin_in,
    output logic           bsr_so,
    output logic [LEN-1:0] upd_q
);

    logic [LEN-1:0] chain_q;

    // One capture/shift cell per boundary position.
    for (genvar g = 0; g < LEN; g++) begin : g_cell
        logic nxt_in;
        if (g == LEN - 1) begin : g_top
            assign nxt_in = tdi;
        end else begin : g_mid
            assign nxt_in = chain_q[g+1];
        end

        // Cell flop: capture pin value or take neighbour during shift.
        always_ff @(posedge tck) begin
            if (!trst_n)       chain_q[g] <= 1'b0;
            else if (cap_en)   chain_q[g] <= pin_in[g];
            else if (shift_en) chain_q[g] <= nxt_in;
        end
    end

    // Update stage: parallel load on Update-DR, cleared by reset.
    always_ff @(posedge tck) begin
        if (!trst_n)     upd_q <= '0;
        else if (upd_en) upd_q <= chain_q;
    end

    assign bsr_so = chain_q[0];

endmodule

// File: rtl/scan_tap.sv
// Boundary-scan test port top: controller, instruction register, bypass
// stage, boundary chain and falling-edge output stage. Assumes trst_n is
// held low over at least one whole tck period.
module scan_tap
    import scan_tap_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_oe,
    output logic [BSR_LEN-1:0] pin_out,
    output logic               pin_drive
);

    tap_state_t      state;
    tap_state_t      state_nxt;
    logic            ir_so;
    logic [IR_W-1:0] ir_active;
    logic            byp_q;
    logic            bsr_so;
    logic            sel_byp;
    logic            bsr_cap;
    logic            bsr_shift;
    logic            bsr_upd;

    scan_tap_fsm u_fsm (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .state     (state),
        .state_nxt (state_nxt)
    );

    scan_tap_ir u_ir (
        .tck       (tck),
        .trst_n    (trst_n),
        .state     (state),
        .state_nxt (state_nxt),
        .tdi       (tdi),
        .ir_so     (ir_so),
        .ir_active (ir_active)
    );

    // Decode of the data register path from the active instruction.
    always_comb begin
        sel_byp   = op_is_bypass(ir_active);
        bsr_cap   = !sel_byp && (state == ST_CAP_DR);
        bsr_shift = !sel_byp && (state == ST_SHIFT_DR);
        bsr_upd   = !sel_byp && (state == ST_UPD_DR);
        pin_drive = op_is_extest(ir_active);
    end

    scan_tap_bsr #(.LEN(BSR_LEN)) u_bsr (
        .tck      (tck),
        .trst_n   (trst_n),
        .cap_en   (bsr_cap),
        .shift_en (bsr_shift),
        .upd_en   (bsr_upd),
        .tdi      (tdi),
        .pin_in   (pin_in),
        .bsr_so   (bsr_so),
        .upd_q    (pin_out)
    );

    // Bypass stage: zero on capture, one-bit delay during shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                                 byp_q <= 1'b0;
        else if (sel_byp && state == ST_CAP_DR)      byp_q <= 1'b0;
        else if (sel_byp && state == ST_SHIFT_DR)    byp_q <= tdi;
    end

    // Output stage on falling edge: drive only in shift states.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (state == ST_SHIFT_IR) begin
            tdo    <= ir_so;
            tdo_oe <= 1'b1;
        end else if (state == ST_SHIFT_DR) begin
            tdo    <= sel_byp ? byp_q : bsr_so;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/scan_tap_checker.sv
// Property checker for scan_tap, bound into every instance.
module scan_tap_checker
    import scan_tap_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               tck,
    input logic               trst_n,
    input tap_state_t         state,
    input logic [IR_W-1:0]    ir_active,
    input logic               byp_q,
    input logic               tdo_oe,
    input logic [BSR_LEN-1:0] pin_out,
    input logic               pin_drive
);

    logic armed;

    // Arms the checks once a reset has been seen at a rising edge.
    always_ff @(posedge tck) begin
        if (!trst_n) armed <= 1'b1;
    end

    AST_RESET_LOADS_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
        (armed && state == ST_RESET) |-> ir_active == OP_BYPASS); // R4

    AST_IR_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
        (armed && $past(trst_n) && $past(state) != ST_UPD_IR && state != ST_RESET)
            |-> $stable(ir_active)); // R7

    AST_BYPASS_CAPTURES_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (armed && $past(trst_n) && $past(state) == ST_CAP_DR && ir_active == OP_BYPASS)
            |-> byp_q == 1'b0); // R3

    AST_OE_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
        armed |-> tdo_oe == (state == ST_SHIFT_IR || state == ST_SHIFT_DR)); // R6

    AST_PINS_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
        (armed && $past(trst_n) && $past(state) != ST_UPD_DR) |-> $stable(pin_out)); // R9

    AST_DRIVE_NEEDS_EXTEST: assert property (@(posedge tck) disable iff (!trst_n)
        (armed && pin_drive) |-> ir_active == OP_EXTEST); // R1

endmodule

bind scan_tap scan_tap_checker #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck       (tck),
    .trst_n    (trst_n),
    .state     (state),
    .ir_active (ir_active),
    .byp_q     (byp_q),
    .tdo_oe    (tdo_oe),
    .pin_out   (pin_out),
    .pin_drive (pin_drive)
);

// File: tb/scan_tap_tb.sv
// Bench for scan_tap: behavioural reference model stepped alongside the
// design, compared every clock, plus directed scans.
module scan_tap_tb;

    localparam int CLK_PERIOD = 20;
    localparam int BW         = 8;
    localparam int WATCHDOG   = 20000;

    // Bench's own controller state numbering.
    localparam int S_RST = 0, S_IDL = 1, S_SDR = 2, S_CDR = 3, S_SHD = 4,
                   S_E1D = 5, S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9,
                   S_CIR = 10, S_SHI = 11, S_E1I = 12, S_PIR = 13,
                   S_E2I = 14, S_UIR = 15;

    logic          tck = 1'b0;
    logic          trst_n = 1'b0;
    logic          tms = 1'b1;
    logic          tdi = 1'b1;
    logic [BW-1:0] pin_in = '0;
    logic          tdo;
    logic          tdo_oe;
    logic [BW-1:0] pin_out;
    logic          pin_drive;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    // Reference model state.
    int      m_st = S_RST;
    bit      m_irs[$];
    bit [1:0] m_ir = 2'b11;
    bit      m_byp = 0;
    bit      m_bsr[$];
    bit [BW-1:0] m_upd = '0;
    bit      m_tdo = 0;
    bit      m_oe = 0;
    bit      obs_tdo;

    scan_tap #(.BSR_LEN(BW)) u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_oe(tdo_oe), .pin_out(pin_out), .pin_drive(pin_drive)
    );

    always #(CLK_PERIOD/2) tck = ~tck;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge tck) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int next_st(int s, bit t);
        case (s)
            S_RST: return t ? S_RST : S_IDL;
            S_IDL: return t ? S_SDR : S_IDL;
            S_SDR: return t ? S_SIR : S_CDR;
            S_CDR: return t ? S_E1D : S_SHD;
            S_SHD: return t ? S_E1D : S_SHD;
            S_E1D: return t ? S_UDR : S_PDR;
            S_PDR: return t ? S_E2D : S_PDR;
            S_E2D: return t ? S_UDR : S_SHD;
            S_UDR: return t ? S_SDR : S_IDL;
            S_SIR: return t ? S_RST : S_CIR;
            S_CIR: return t ? S_E1I : S_SHI;
            S_SHI: return t ? S_E1I : S_SHI;
            S_E1I: return t ? S_UIR : S_PIR;
            S_PIR: return t ? S_E2I : S_PIR;
            S_E2I: return t ? S_UIR : S_SHI;
            default: return t ? S_SDR : S_IDL;
        endcase
    endfunction

    // Model step at the rising edge using the inputs just applied.
    task automatic model_rise(input bit t, input bit d);
        if (!trst_n) begin
            m_st = S_RST; m_ir = 2'b11; m_upd = '0;
            return;
        end
        case (m_st)
            S_CIR: begin m_irs.delete(); m_irs.push_back(1); m_irs.push_back(0); end
            S_SHI: begin void'(m_irs.pop_front()); m_irs.push_back(d); end
            S_UIR: m_ir = {m_irs[1], m_irs[0]};
            S_CDR: if (m_ir == 2'b11) m_byp = 0;
                   else begin
                       m_bsr.delete();
                       for (int i = 0; i < BW; i++) m_bsr.push_back(pin_in[i]);
                   end
            S_SHD: if (m_ir == 2'b11) m_byp = d;
                   else begin void'(m_bsr.pop_front()); m_bsr.push_back(d); end
            S_UDR: if (m_ir != 2'b11)
                       for (int i = 0; i < BW; i++) m_upd[i] = m_bsr[i];
            default: ;
        endcase
        m_st = next_st(m_st, t);
        if (m_st == S_RST) m_ir = 2'b11;
    endtask

    // Model step at the falling edge.
    task automatic model_fall();
        if (trst_n && m_st == S_SHI) begin
            m_tdo = m_irs[0]; m_oe = 1;
        end else if (trst_n && m_st == S_SHD) begin
            m_tdo = (m_ir == 2'b11) ? m_byp : m_bsr[0]; m_oe = 1;
        end else begin
            m_tdo = 0; m_oe = 0;
        end
    endtask

    task automatic cmp_outputs();
        chk(tdo_oe == m_oe, "R6 tdo_oe", tdo_oe, m_oe);
        chk(tdo == m_tdo, "R5 tdo", tdo, m_tdo);
        chk(pin_out == m_upd, "R9 pin_out", pin_out, m_upd);
        chk(pin_drive == (m_ir == 2'b00), "R1 pin_drive", pin_drive, m_ir == 2'b00);
    endtask

    // One clock: drive, check outputs hold over the rise, compare after fall.
    task automatic tick(input bit t, input bit d);
        tms = t; tdi = d;
        @(posedge tck);
        model_rise(t, d);
        #1;
        chk(tdo == m_tdo && tdo_oe == m_oe, "R5 hold over rise",
            {tdo, tdo_oe}, {m_tdo, m_oe});
        @(negedge tck);
        model_fall();
        #1;
        cmp_outputs();
        obs_tdo = tdo;
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) tick(1, 0);
        tick(0, 0);
    endtask

    // IR scan from idle; returns the two captured bits seen on tdo.
    task automatic scan_ir(input bit [1:0] code, output bit [1:0] seen);
        tick(1, 0); tick(1, 0); tick(0, 0);
        tick(0, 0); seen[0] = obs_tdo;
        seen[1] = 0;
        tick(0, code[0]); seen[1] = obs_tdo;
        tick(1, code[1]);
        tick(1, 0); tick(0, 0);
    endtask

    // DR scan of n bits from idle; returns bits seen on tdo.
    task automatic scan_dr(input bit [15:0] data, input int n, output bit [15:0] seen);
        seen = '0;
        tick(1, 0); tick(0, 0);
        tick(0, 0); seen[0] = obs_tdo;
        for (int i = 0; i < n - 1; i++) begin
            tick(0, data[i]); seen[i+1] = obs_tdo;
        end
        tick(1, data[n-1]);
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        bit [1:0]  irs;
        bit [15:0] got;
        bit [15:0] exp;

        // R10: reset held for two clocks.
        trst_n = 0;
        tick(1, 1); tick(1, 1);
        chk(tdo_oe == 0 && pin_out == '0 && pin_drive == 0, "R10 reset state",
            {tdo_oe, pin_out, pin_drive}, 0);
        trst_n = 1;
        tick(0, 0);

        // R3/R10: after reset, a DR scan goes through the one-bit bypass.
        scan_dr(16'h00B6, 8, got);
        exp = {8'h0, 8'hB6 << 1};
        chk(got[7:0] == exp[7:0], "R3 bypass delay after reset", got[7:0], exp[7:0]);

        // R7: captured instruction pattern reads back as 01, LSB first.
        scan_ir(2'b01, irs);
        chk(irs == 2'b01, "R7 capture pattern", irs, 2'b01);

        // R2/R8: code 01 samples pins; bit 0 comes out first.
        pin_in = 8'hA5;
        scan_dr(16'h003C, 8, got);
        chk(got[7:0] == 8'hA5, "R8 chain order from pins", got[7:0], 8'hA5);
        chk(pin_drive == 0, "R2 code 01 keeps pins with core", pin_drive, 0);
        chk(pin_out == 8'h3C, "R9 preload to update stage", pin_out, 8'h3C);

        // R2: code 10 behaves the same.
        scan_ir(2'b10, irs);
        pin_in = 8'h4E;
        scan_dr(16'h0081, 8, got);
        chk(got[7:0] == 8'h4E, "R2 code 10 samples pins", got[7:0], 8'h4E);
        chk(pin_drive == 0, "R2 code 10 no drive", pin_drive, 0);
        chk(pin_out == 8'h81, "R9 code 10 update", pin_out, 8'h81);

        // R1: external test drives pins with the update stage.
        scan_ir(2'b00, irs);
        chk(pin_drive == 1, "R1 extest drives", pin_drive, 1);
        chk(pin_out == 8'h81, "R9 pins hold through IR scan", pin_out, 8'h81);
        pin_in = 8'h17;
        scan_dr(16'h00F0, 8, got);
        chk(got[7:0] == 8'h17, "R8 extest capture", got[7:0], 8'h17);
        chk(pin_out == 8'hF0, "R9 extest update", pin_out, 8'hF0);

        // R4: five tms-high clocks return to reset and reload bypass.
        for (int i = 0; i < 5; i++) tick(1, 0);
        chk(pin_drive == 0, "R4 reset state reloads bypass", pin_drive, 0);
        tick(0, 0);
        scan_dr(16'h005A, 8, got);
        exp = {8'h0, 8'h5A << 1};
        chk(got[7:0] == exp[7:0], "R4 bypass after tms reset", got[7:0], exp[7:0]);
        chk(pin_out == 8'hF0, "R9 bypass update leaves pins", pin_out, 8'hF0);

        // R7: pause and resume in IR path, then DR scans leave IR alone.
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        tick(1, 0); tick(0, 0); tick(1, 0);
        tick(1, 0); tick(0, 0);
        chk(pin_drive == 1, "R7 update after pause sets extest", pin_drive, 1);

        // R10: mid-scan reset clears update stage and instruction.
        tick(1, 0); tick(0, 0); tick(0, 0);
        trst_n = 0;
        tick(0, 1); tick(0, 1);
        chk(pin_out == '0 && pin_drive == 0 && tdo_oe == 0, "R10 mid-scan reset",
            {pin_out, pin_drive, tdo_oe}, 0);
        trst_n = 1;
        to_idle();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule